// File: doc/BRIEF.md
# Interleaved Video Scan Address Generator

This block holds the horizontal and vertical raster counters of a 40-column text and low-resolution display. On every scan cycle it turns the current raster position into a byte address inside a 1 KB display page based at hex 400. Display RAM is read once per scan cycle in both active video and blanking.

Text rows are not laid out linearly. Eight consecutive text rows form a group and sit 128 bytes apart. Each following group of eight is shifted by 40 bytes. Because of this folding, the scan visits every refresh row of the dynamic memory often enough to keep it alive, with no extra refresh cycles. The block also outputs a 7-bit refresh row index. This index names the dynamic-memory row that each scan cycle touches. The horizontal, vertical and visible-area flags let downstream video logic blank its output.

The counters advance on every clock, one clock per character position. A synchronous active-high reset returns the scan to the top-left position.

Top module: `vscan_addr_gen`

## Requirements
- R1: While and right after reset, the scan sits at column 0 of line 0: scan_addr is hex 400, visible is 1, hblank and vblank are 0, and refresh_row is 0.
- R2: A line lasts 65 clocks. hblank is 0 for the first 40 column positions (0..39) and 1 for positions 40..64. The next line then starts again at column 0.
- R3: A frame lasts 262 lines. vblank is 0 on lines 0..191 and 1 on lines 192..261. After the last column of line 261 the scan returns to column 0 of line 0.
- R4: Text row r covers lines 8r..8r+7. For rows 0 to 7, column 0 reads hex 400 + hex 80 × r (hex 400, 480, ... 780).
- R5: Each later group of eight rows is shifted by hex 28. Rows 8..15 start at the first group's starts plus hex 28 (row 8 at hex 428). Rows 16..23 start at those starts plus hex 50 (row 16 at hex 450, row 23 at hex 7D0).
- R6: Within a visible line the address is the start of that line's text row plus the column number, so it rises by exactly 1 from column to column.
- R7: visible is 1 exactly when both hblank and vblank are 0.
- R8: The address keeps advancing during blanking as well. At every position, scan_addr = hex 400 + ((128 × (row mod 8) + 40 × (row div 8) + column) mod 1024), where row = line div 8. The address therefore always stays within hex 400..7FF.
- R9: refresh_row is formed from the raster position. Bit 0 is line bit 0, bit 1 is column bit 2, bit 2 is column bit 0, bit 3 is column bit 1, and bits 4, 5 and 6 are column bits 3, 4 and 5. All 128 values appear within any 130 consecutive scan cycles, which is well inside 2 ms of scan time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock, one cycle per character position |
| rst | input | 1 | Synchronous active-high reset |
| scan_addr | output | 16 | Display page byte address for the current position |
| visible | output | 1 | High inside the 40 × 192 active area |
| hblank | output | 1 | High during horizontal blanking (columns 40..64) |
| vblank | output | 1 | High during vertical blanking (lines 192..261) |
| refresh_row | output | 7 | Dynamic-memory row index touched this cycle |

## Verification
The bench builds the block with its default geometry: 65 columns, 262 lines, 8 lines per text row, 8 rows per group, a 128-byte stride and a 40-byte group shift. With these values a full frame of 17030 cycles is short enough to compare every position, including the blanking positions where the address runs past the visible rows. These values also put the line and frame wraps, the group boundaries at rows 8 and 16, and windows that straddle the frame wrap within reach of the refresh-coverage checks.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

    localparam int REFRESH_BITS = 7;

    typedef struct packed {
        logic hblank;
        logic vblank;
        logic visible;
    } scan_flags_t;

    // Byte offset inside the page for a raster position (folded row layout).
    function automatic int page_offset(
        input int col,
        input int line,
        input int lines_per_row,
        input int rows_per_group,
        input int row_stride,
        input int group_step,
        input int page_size
    );
        int text_row;
        int in_group;
        int group_idx;
        text_row  = line / lines_per_row;
        in_group  = text_row % rows_per_group;
        group_idx = text_row / rows_per_group;
        return (in_group * row_stride + group_idx * group_step + col) % page_size;
    endfunction

    // Memory row touched by a scan cycle: low bits from line bit 0, column bits 2 and 0.
    function automatic logic [REFRESH_BITS-1:0] refresh_index(
        input logic [5:0] col_lo,
        input logic       line_lsb
    );
        return {col_lo[5], col_lo[4], col_lo[3], col_lo[1], col_lo[0], col_lo[2], line_lsb};
    endfunction

endpackage

// File: rtl/vscan_hcounter.sv
module vscan_hcounter #(
    parameter int TOTAL   = 65,
    parameter int VISIBLE = 40,
    localparam int W      = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count,
    output logic         line_end,
    output logic         blank
);
    localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
    localparam logic [W-1:0] VIS_LIM = W'(VISIBLE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (count == LAST)
            count <= '0;
        else
            count <= count + 1'b1;
    end

    assign line_end = (count == LAST);
    assign blank    = (count >= VIS_LIM);

    // R2: one step per clock inside a line
    p_h_step_r2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> count == $past(count) + 1'b1)
        else $error("p_h_step_r2");

    // R2: wrap after the last position
    p_h_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> count == '0)
        else $error("p_h_wrap_r2");

    // R2: blanking starts exactly at the first non-visible column
    p_hblank_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(blank) |-> count == VIS_LIM)
        else $error("p_hblank_start_r2");
endmodule

// File: rtl/vscan_vcounter.sv
module vscan_vcounter #(
    parameter int TOTAL   = 262,
    parameter int VISIBLE = 192,
    localparam int W      = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    output logic [W-1:0] count,
    output logic         blank
);
    localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
    localparam logic [W-1:0] VIS_LIM = W'(VISIBLE);

    logic at_last;
    assign at_last = (count == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (advance)
            count <= at_last ? '0 : count + 1'b1;
    end

    assign blank = (count >= VIS_LIM);

    // R3: the line number only moves at a line end
    p_v_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(count))
        else $error("p_v_hold_r3");

    // R3: frame wraps after the last line
    p_v_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && at_last) |=> count == '0)
        else $error("p_v_wrap_r3");

    // R3: vertical blanking begins right after the last visible line
    p_vblank_start_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && count == VIS_LIM - 1'b1) |=> blank)
        else $error("p_vblank_start_r3");
endmodule

// File: rtl/vscan_addr_map.sv
module vscan_addr_map
    import vscan_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int PAGE_BASE      = 'h400,
    parameter int PAGE_SIZE      = 1024,
    parameter int H_W            = 7,
    parameter int V_W            = 9,
    parameter int LINES_PER_ROW  = 8,
    parameter int ROWS_PER_GROUP = 8,
    parameter int ROW_STRIDE     = 128,
    parameter int GROUP_STEP     = 40
) (
    input  logic [H_W-1:0]          col,
    input  logic [V_W-1:0]          line,
    output logic [ADDR_W-1:0]       addr,
    output logic [REFRESH_BITS-1:0] refresh_row
);
    int off_i;

    always_comb begin
        off_i = page_offset(int'(col), int'(line), LINES_PER_ROW, ROWS_PER_GROUP,
                            ROW_STRIDE, GROUP_STEP, PAGE_SIZE);
        addr  = ADDR_W'(PAGE_BASE + off_i);
    end

    assign refresh_row = refresh_index(col[5:0], line[0]);
endmodule

// File: rtl/vscan_addr_gen.sv
module vscan_addr_gen
    import vscan_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int PAGE_BASE      = 'h400,
    parameter int PAGE_SIZE      = 1024,
    parameter int H_TOTAL        = 65,
    parameter int H_VISIBLE      = 40,
    parameter int V_TOTAL        = 262,
    parameter int V_VISIBLE      = 192,
    parameter int LINES_PER_ROW  = 8,
    parameter int ROWS_PER_GROUP = 8,
    parameter int ROW_STRIDE     = 128,
    parameter int GROUP_STEP     = 40
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic [ADDR_W-1:0]       scan_addr,
    output logic                    visible,
    output logic                    hblank,
    output logic                    vblank,
    output logic [REFRESH_BITS-1:0] refresh_row
);
    localparam int H_W = $clog2(H_TOTAL);
    localparam int V_W = $clog2(V_TOTAL);

    logic [H_W-1:0] col;
    logic [V_W-1:0] line;
    logic           line_end;
    scan_flags_t    flags;

    vscan_hcounter #(.TOTAL(H_TOTAL), .VISIBLE(H_VISIBLE)) u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .count    (col),
        .line_end (line_end),
        .blank    (flags.hblank)
    );

    vscan_vcounter #(.TOTAL(V_TOTAL), .VISIBLE(V_VISIBLE)) u_vcnt (
        .clk     (clk),
        .rst     (rst),
        .advance (line_end),
        .count   (line),
        .blank   (flags.vblank)
    );

    vscan_addr_map #(
        .ADDR_W         (ADDR_W),
        .PAGE_BASE      (PAGE_BASE),
        .PAGE_SIZE      (PAGE_SIZE),
        .H_W            (H_W),
        .V_W            (V_W),
        .LINES_PER_ROW  (LINES_PER_ROW),
        .ROWS_PER_GROUP (ROWS_PER_GROUP),
        .ROW_STRIDE     (ROW_STRIDE),
        .GROUP_STEP     (GROUP_STEP)
    ) u_map (
        .col         (col),
        .line        (line),
        .addr        (scan_addr),
        .refresh_row (refresh_row)
    );

    assign flags.visible = !(flags.hblank || flags.vblank);
    assign hblank        = flags.hblank;
    assign vblank        = flags.vblank;
    assign visible       = flags.visible;

    // R6: address steps by one between neighbouring visible columns
    p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
        (visible && int'(col) < H_VISIBLE - 1) |=> scan_addr == $past(scan_addr) + 1'b1)
        else $error("p_col_step_r6");

    // R8: the address never leaves the display page
    p_addr_in_page_r8: assert property (@(posedge clk) disable iff (rst)
        int'(scan_addr) >= PAGE_BASE && int'(scan_addr) < PAGE_BASE + PAGE_SIZE)
        else $error("p_addr_in_page_r8");

    // R7: leaving the active columns drops the visible flag
    p_vis_drop_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(hblank) |-> !visible)
        else $error("p_vis_drop_r7");

    // R9: refresh row bit 0 alternates from line to line
    p_refresh_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        line_end |=> refresh_row[0] != $past(refresh_row[0]))
        else $error("p_refresh_toggle_r9");
endmodule

// File: tb/vscan_addr_gen_bench.sv
module vscan_addr_gen_bench;

    localparam int H_TOT   = 65;
    localparam int H_VIS   = 40;
    localparam int V_TOT   = 262;
    localparam int V_VIS   = 192;
    localparam int WDOG    = 195000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] scan_addr;
    logic        visible, hblank, vblank;
    logic [6:0]  refresh_row;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int bh = 0;
    int bv = 0;

    always #2 clk = ~clk;

    vscan_addr_gen u_vscan_addr_gen (
        .clk         (clk),
        .rst         (rst),
        .scan_addr   (scan_addr),
        .visible     (visible),
        .hblank      (hblank),
        .vblank      (vblank),
        .refresh_row (refresh_row)
    );

    // Raster position expected from R2/R3 timing.
    always @(posedge clk) begin
        if (rst) begin
            bh <= 0;
            bv <= 0;
        end else if (bh == H_TOT - 1) begin
            bh <= 0;
            bv <= (bv == V_TOT - 1) ? 0 : bv + 1;
        end else begin
            bh <= bh + 1;
        end
    end

    function automatic int exp_addr(int h, int v);
        int r;
        r = v / 8;
        return 'h400 + (((r % 8) * 128 + (r / 8) * 40 + h) % 1024);
    endfunction

    function automatic int exp_refresh(int h, int v);
        int b;
        b = (v & 1)
          | (((h >> 2) & 1) << 1)
          | ((h & 1) << 2)
          | (((h >> 1) & 1) << 3)
          | (((h >> 3) & 1) << 4)
          | (((h >> 4) & 1) << 5)
          | (((h >> 5) & 1) << 6);
        return b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at h=%0d v=%0d: got %0h expected %0h", tag, bh, bv, act, exp);
        end
    endtask

    task automatic goto_pos(input int h, input int v);
        @(negedge clk);
        while (!(bh == h && bv == v)) @(negedge clk);
    endtask

    task automatic t_reset_state;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(scan_addr == 16'h0400, "R1 addr in reset", scan_addr, 'h400);
        chk(visible == 1'b1, "R1 visible in reset", visible, 1);
        chk(hblank == 1'b0 && vblank == 1'b0, "R1 blanks in reset", {hblank, vblank}, 0);
        chk(refresh_row == 7'd0, "R1 refresh in reset", refresh_row, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(scan_addr == 16'h0401, "R1 first step after reset", scan_addr, 'h401);
    endtask

    task automatic t_full_frame;
        goto_pos(0, 0);
        for (int i = 0; i < H_TOT * V_TOT; i++) begin
            chk(int'(scan_addr) == exp_addr(bh, bv), "R8 address formula", scan_addr, exp_addr(bh, bv));
            if (bh < H_VIS && bv < V_VIS)
                chk(int'(scan_addr) == exp_addr(0, bv) + bh, "R6 column offset", scan_addr, exp_addr(0, bv) + bh);
            chk(hblank == (bh >= H_VIS), "R2 hblank", hblank, int'(bh >= H_VIS));
            chk(vblank == (bv >= V_VIS), "R3 vblank", vblank, int'(bv >= V_VIS));
            chk(visible == (bh < H_VIS && bv < V_VIS), "R7 visible", visible, int'(bh < H_VIS && bv < V_VIS));
            chk(int'(refresh_row) == exp_refresh(bh, bv), "R9 refresh bits", refresh_row, exp_refresh(bh, bv));
            @(negedge clk);
        end
    endtask

    task automatic t_row_starts;
        for (int r = 0; r < 24; r++) begin
            int e;
            e = 'h400 + (r % 8) * 'h80 + (r / 8) * 'h28;
            goto_pos(0, r * 8);
            chk(int'(scan_addr) == e, (r < 8) ? "R4 row start" : "R5 row start", scan_addr, e);
            if (r == 8)  chk(scan_addr == 16'h0428, "R5 row 8 at 428", scan_addr, 'h428);
            if (r == 16) chk(scan_addr == 16'h0450, "R5 row 16 at 450", scan_addr, 'h450);
            if (r == 23) chk(scan_addr == 16'h07D0, "R5 row 23 at 7D0", scan_addr, 'h7D0);
            if (r == 7)  chk(scan_addr == 16'h0780, "R4 row 7 at 780", scan_addr, 'h780);
        end
    endtask

    task automatic t_line_timing;
        int start;
        goto_pos(0, 9);
        start = int'(scan_addr);
        for (int c = 0; c < H_TOT; c++) begin
            chk(hblank == (c >= H_VIS), "R2 hblank span", hblank, int'(c >= H_VIS));
            @(negedge clk);
        end
        chk(hblank == 1'b0, "R2 new line after 65 clocks", hblank, 0);
        chk(int'(scan_addr) == start, "R2 line restarts at column 0", scan_addr, start);
    endtask

    task automatic t_frame_timing;
        goto_pos(H_TOT - 1, V_VIS - 1);
        chk(vblank == 1'b0, "R3 last visible line", vblank, 0);
        @(negedge clk);
        chk(vblank == 1'b1, "R3 vblank starts at 192", vblank, 1);
        chk(visible == 1'b0, "R7 visible low in vblank", visible, 0);
        goto_pos(H_TOT - 1, V_TOT - 1);
        chk(vblank == 1'b1, "R3 vblank at line 261", vblank, 1);
        @(negedge clk);
        chk(vblank == 1'b0, "R3 frame wrap", vblank, 0);
        chk(scan_addr == 16'h0400, "R3 frame wrap addr", scan_addr, 'h400);
    endtask

    task automatic t_refresh(input int h0, input int v0, input int win);
        bit [127:0] seen;
        seen = '0;
        goto_pos(h0, v0);
        for (int i = 0; i < win; i++) begin
            seen[refresh_row] = 1'b1;
            @(negedge clk);
        end
        chk($countones(seen) == 128, "R9 refresh coverage", $countones(seen), 128);
    endtask

    task automatic t_refresh_points;
        goto_pos(5, 1);
        chk(refresh_row == 7'h07, "R9 bit order h=5 v=1", refresh_row, 'h07);
        goto_pos(42, 2);
        chk(refresh_row == 7'h58, "R9 bit order h=42 v=2", refresh_row, 'h58);
    endtask

    initial begin
        t_reset_state();
        t_full_frame();
        t_row_starts();
        t_line_timing();
        t_frame_timing();
        t_refresh_points();
        t_refresh(0, 10, 130);
        t_refresh(17, 100, 130);
        t_refresh(10, 261, 130);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got %0d cycles expected fewer", WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule